// File: doc/BRIEF.md
# Interrupt Event Aggregator with Toggle-on-Write Status

This block gathers twelve single-cycle event pulses from a bus bridge into a status register. Each status bit has its own mask bit in an enable register. A single global enable gates the combined request, which goes out on one registered interrupt line. A simple 32-bit register port gives access to three registers: the global enable, the status and the per-source enables. The port has a valid strobe, a write flag, a word offset and read data that returns one cycle later.

All register bit positions are given in MSB-first numbering, where bit 0 is the most significant bit of the 32-bit word. Position k therefore maps to vector index 31-k. Software clears a status bit by writing one to it. Writing one to a bit that is already clear sets that bit. Firmware can use this to raise an interrupt by hand.

Top module: `irq_agg_regs`

## Requirements
- R1: After a synchronous reset, the status, enable and global enable registers are zero. `irq_out`, `reg_rvalid` and `reg_rdata` are also zero.
- R2: A pulse on `evt_pulse[i]` sets status bit i on the next clock edge. Source i sits at MSB-first position 15+i of the status register at offset 1, which is vector index 16-i.
- R3: A write to offset 1 inverts every source bit whose data bit is one. Data bits that are zero leave their source bits unchanged.
- R4: If an event pulse and a toggle write hit the same status bit in the same cycle, that bit ends up set.
- R5: Status positions that carry no source (MSB-first 0..14 and 27..31) always read as zero, whatever has been written to them.
- R6: The enable register at offset 2 is plain read/write, with the same source positions as the status register. Its other positions read as zero.
- R7: The global enable register at offset 0 holds one read/write bit at MSB-first position 0 (vector index 31). All other positions read as zero.
- R8: `irq_out` equals the global enable ANDed with the OR over all (status AND enable) bits, taken from the register values one cycle earlier.
- R9: A read (valid, write low) returns the register value in `reg_rdata` on the next cycle, with `reg_rvalid` high for exactly that cycle.
- R10: Writes to offsets 3 and above change no register. Reads from those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 12 | One-cycle event pulses, index i = source i |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word offset: 0 global enable, 1 status, 2 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the request |
| reg_rvalid | output | 1 | Read data valid pulse |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
A hardware event and a software toggle write can land on the same status bit in the same clock. The event should set the bit, and the write would otherwise flip it. The bench drives both in one cycle, on bits that were clear and on bits that were already set. It also keeps this collision in its random phase, and its own behavioural model decides that the bit ends set. In the same way, enable or global enable writes can coincide with status changes. The one-cycle lag of `irq_out` is then compared against the model on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int BUS_W    = 32;
    localparam int SRC_N    = 12;
    localparam int SRC_BASE = 15;   // MSB-first position of source 0
    localparam int ADDR_W   = 4;

    localparam int OFF_GIE  = 0;
    localparam int OFF_STAT = 1;
    localparam int OFF_EN   = 2;

    typedef enum logic [1:0] {
        SEL_GIE  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } reg_cmd_t;

    // MSB-first position -> vector index in a word of width w
    function automatic int msbf_to_idx(input int pos, input int w);
        return w - 1 - pos;
    endfunction

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                valid,
    input  logic                write,
    input  logic [ADDR_W_P-1:0] addr,
    output reg_cmd_t            cmd
);

    reg_sel_e sel;

    always_comb begin
        if (addr == ADDR_W_P'(OFF_GIE))
            sel = SEL_GIE;
        else if (addr == ADDR_W_P'(OFF_STAT))
            sel = SEL_STAT;
        else if (addr == ADDR_W_P'(OFF_EN))
            sel = SEL_EN;
        else
            sel = SEL_NONE;
    end

    always_comb begin
        cmd.wr  = valid && write;
        cmd.rd  = valid && !write;
        cmd.sel = sel;
    end

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
    parameter int SRC_N_P = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SRC_N_P-1:0] evt,
    input  logic               tog_en,
    input  logic [SRC_N_P-1:0] tog_bits,
    output logic [SRC_N_P-1:0] stat_q
);

    logic [SRC_N_P-1:0] tog_mask;
    logic [SRC_N_P-1:0] stat_d;

    always_comb begin
        tog_mask = tog_en ? tog_bits : '0;
        // event wins over a toggle landing in the same cycle
        stat_d   = (stat_q ^ tog_mask) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine #(
    parameter int SRC_N_P = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SRC_N_P-1:0] stat,
    input  logic [SRC_N_P-1:0] en,
    input  logic               gie,
    output logic               irq_q
);

    logic any_pending;

    always_comb any_pending = |(stat & en);

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= gie && any_pending;
    end

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int BUS_W_P    = BUS_W,
    parameter int SRC_N_P    = SRC_N,
    parameter int SRC_BASE_P = SRC_BASE,
    parameter int ADDR_W_P   = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SRC_N_P-1:0]  evt_pulse,
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [ADDR_W_P-1:0] reg_addr,
    input  logic [BUS_W_P-1:0]  reg_wdata,
    output logic [BUS_W_P-1:0]  reg_rdata,
    output logic                reg_rvalid,
    output logic                irq_out
);

    localparam int GIE_IDX = BUS_W_P - 1;

    reg_cmd_t           cmd;
    logic [SRC_N_P-1:0] stat_q;
    logic [SRC_N_P-1:0] en_q;
    logic               gie_q;
    logic [SRC_N_P-1:0] wr_src;
    logic [BUS_W_P-1:0] stat_word;
    logic [BUS_W_P-1:0] en_word;
    logic [BUS_W_P-1:0] gie_word;
    logic [BUS_W_P-1:0] rd_word;

    irq_agg_decode #(.ADDR_W_P(ADDR_W_P)) u_dec (
        .valid (reg_valid),
        .write (reg_write),
        .addr  (reg_addr),
        .cmd   (cmd)
    );

    // gather source fields out of the bus word and spread them back
    for (genvar i = 0; i < SRC_N_P; i++) begin : g_map
        localparam int IDX = BUS_W_P - 1 - (SRC_BASE_P + i);
        assign wr_src[i] = reg_wdata[IDX];
    end

    always_comb begin
        stat_word = '0;
        en_word   = '0;
        for (int i = 0; i < SRC_N_P; i++) begin
            stat_word[msbf_to_idx(SRC_BASE_P + i, BUS_W_P)] = stat_q[i];
            en_word[msbf_to_idx(SRC_BASE_P + i, BUS_W_P)]   = en_q[i];
        end
        gie_word          = '0;
        gie_word[GIE_IDX] = gie_q;
    end

    irq_agg_status #(.SRC_N_P(SRC_N_P)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .tog_en   (cmd.wr && (cmd.sel == SEL_STAT)),
        .tog_bits (wr_src),
        .stat_q   (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else if (cmd.wr) begin
            if (cmd.sel == SEL_EN)
                en_q <= wr_src;
            if (cmd.sel == SEL_GIE)
                gie_q <= reg_wdata[GIE_IDX];
        end
    end

    irq_agg_combine #(.SRC_N_P(SRC_N_P)) u_comb (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat_q),
        .en    (en_q),
        .gie   (gie_q),
        .irq_q (irq_out)
    );

    always_comb begin
        unique case (cmd.sel)
            SEL_GIE:  rd_word = gie_word;
            SEL_STAT: rd_word = stat_word;
            SEL_EN:   rd_word = en_word;
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= cmd.rd;
            if (cmd.rd)
                reg_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int BUS_W_P  = BUS_W,
    parameter int SRC_N_P  = SRC_N,
    parameter int ADDR_W_P = ADDR_W
) (
    input logic                clk,
    input logic                rst,
    input logic [SRC_N_P-1:0]  evt_pulse,
    input logic                reg_valid,
    input logic                reg_write,
    input logic [ADDR_W_P-1:0] reg_addr,
    input logic [BUS_W_P-1:0]  reg_rdata,
    input logic                reg_rvalid,
    input logic                irq_out,
    input logic [SRC_N_P-1:0]  stat_q,
    input logic [SRC_N_P-1:0]  en_q,
    input logic                gie_q
);

    logic unmapped;
    always_comb unmapped = reg_addr > ADDR_W_P'(OFF_EN);

    // R2 / R4: any pulsed source is set on the following cycle
    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: status holds when neither an event nor a write occurs
    assert_stat_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse == '0 && !(reg_valid && reg_write)) |=> $stable(stat_q));

    // R8: no interrupt without a global enable in the previous cycle
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(gie_q));

    // R8: interrupt needs an enabled pending source in the previous cycle
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ($past(stat_q & en_q) != '0));

    // R9: every read is answered one cycle later, and only reads are
    assert_rd_answer_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && !reg_write) |=> reg_rvalid);
    assert_rvalid_src_R9: assert property (@(posedge clk) disable iff (rst)
        reg_rvalid |-> $past(reg_valid && !reg_write));

    // R10: unmapped reads return zero, unmapped writes change nothing
    assert_unmapped_rd_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && !reg_write && unmapped) |=> (reg_rdata == '0));
    assert_unmapped_wr_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_write && unmapped) |=> ($stable(en_q) && $stable(gie_q)));

endmodule

bind irq_agg_regs irq_agg_chk #(
    .BUS_W_P  (BUS_W_P),
    .SRC_N_P  (SRC_N_P),
    .ADDR_W_P (ADDR_W_P)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_pulse  (evt_pulse),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .irq_out    (irq_out),
    .stat_q     (stat_q),
    .en_q       (en_q),
    .gie_q      (gie_q)
);

// File: tb/irq_agg_regs_test.sv
module irq_agg_regs_test;

    localparam int W  = 32;
    localparam int N  = 12;
    localparam int B  = 15;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  evt_pulse = '0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [AW-1:0] reg_addr  = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          reg_rvalid;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;   // 50 MHz

    irq_agg_regs uut (
        .clk        (clk),
        .rst        (rst),
        .evt_pulse  (evt_pulse),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .irq_out    (irq_out)
    );

    // ---------------- behavioural reference model ----------------
    bit [N-1:0] m_stat, m_en;
    bit         m_gie, m_irq, m_rvalid;
    bit [W-1:0] m_rdata;

    function automatic bit [W-1:0] model_word(input int off);
        bit [W-1:0] w = '0;
        if (off == 0) w[W-1] = m_gie;
        else if (off == 1 || off == 2) begin
            for (int k = 0; k < W; k++)
                if (k >= B && k < B + N)
                    w[W-1-k] = (off == 1) ? m_stat[k-B] : m_en[k-B];
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stat <= '0; m_en <= '0; m_gie <= 0; m_irq <= 0;
            m_rvalid <= 0; m_rdata <= '0;
        end else begin
            bit [N-1:0] ns;
            ns = m_stat;
            for (int i = 0; i < N; i++) begin
                if (reg_valid && reg_write && reg_addr == 1 && reg_wdata[W-1-(B+i)])
                    ns[i] = !ns[i];
                if (evt_pulse[i]) ns[i] = 1'b1;
            end
            m_stat <= ns;
            m_irq  <= m_gie && ((m_stat & m_en) != 0);
            if (reg_valid && reg_write && reg_addr == 2)
                for (int i = 0; i < N; i++) m_en[i] <= reg_wdata[W-1-(B+i)];
            if (reg_valid && reg_write && reg_addr == 0)
                m_gie <= reg_wdata[W-1];
            m_rvalid <= reg_valid && !reg_write;
            if (reg_valid && !reg_write)
                m_rdata <= model_word(int'(reg_addr));
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R8", W'(irq_out), W'(m_irq));
            check("R9", W'(reg_rvalid), W'(m_rvalid));
            check(cur_req, reg_rdata, m_rdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle();
        reg_valid = 0; reg_write = 0; evt_pulse = '0;
        @(negedge clk);
    endtask

    task automatic wr(input int off, input logic [W-1:0] d, input logic [N-1:0] e = '0);
        reg_valid = 1; reg_write = 1; reg_addr = AW'(off); reg_wdata = d; evt_pulse = e;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input int off);
        reg_valid = 1; reg_write = 0; reg_addr = AW'(off); evt_pulse = '0;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse(input logic [N-1:0] e);
        evt_pulse = e; reg_valid = 0;
        @(negedge clk);
        idle();
    endtask

    function automatic logic [W-1:0] src_bit(input int i);
        logic [W-1:0] w = '0;
        w[W-1-(B+i)] = 1'b1;
        return w;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: outputs after reset, then each register reads zero
        check("R1", {reg_rdata[W-3:0], reg_rvalid, irq_out}, '0);
        cur_req = "R1";
        rd(0); rd(1); rd(2);

        // R2: walk each source alone
        cur_req = "R2";
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            rd(1);
            check("R2", reg_rdata & src_bit(i), src_bit(i));
        end

        // R7: global enable bit only at MSB
        cur_req = "R7";
        wr(0, '1); rd(0);
        check("R7", reg_rdata, 32'h8000_0000);
        wr(0, 32'h7FFF_FFFF); rd(0);

        // R6: enable register
        cur_req = "R6";
        wr(2, '1); rd(2);
        check("R6", reg_rdata, 32'h0001_FFE0);
        wr(2, 32'h0000_A5A0); rd(2);

        // R8: gating by enable and global enable
        cur_req = "R8";
        wr(0, 32'h8000_0000); idle(); idle();
        wr(2, 32'h0); idle(); idle();
        wr(2, src_bit(3)); idle(); idle();
        wr(0, 32'h0); idle(); idle();

        // R3: toggle clears set bits, sets clear bits, zero leaves alone
        cur_req = "R3";
        wr(1, src_bit(0) | src_bit(5)); rd(1);
        check("R3", reg_rdata & (src_bit(0) | src_bit(5)), '0);
        wr(1, src_bit(0)); rd(1);
        check("R3", reg_rdata & src_bit(0), src_bit(0));
        wr(1, 32'h0); rd(1);

        // R4: event and toggle collide on a clear bit and on a set bit
        cur_req = "R4";
        wr(1, src_bit(7), N'(1) << 7); rd(1);
        check("R4", reg_rdata & src_bit(7), src_bit(7));
        wr(1, src_bit(7), N'(1) << 7); rd(1);
        check("R4", reg_rdata & src_bit(7), src_bit(7));

        // R5: unassigned status positions stay zero
        cur_req = "R5";
        wr(1, 32'hFFFE_001F); rd(1);
        check("R5", reg_rdata & 32'hFFFE_001F, '0);

        // R10: unmapped offsets
        cur_req = "R10";
        for (int a = 3; a < 16; a++) begin
            wr(a, '1); rd(a);
            check("R10", reg_rdata, '0);
        end
        rd(0); rd(2);

        // mixed traffic, including collisions (R4, R8)
        cur_req = "R4";
        begin
            logic [31:0] lf = 32'hACE1_1234;
            for (int n = 0; n < 400; n++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                evt_pulse = (lf[3:0] == 0) ? N'(lf[27:16]) : '0;
                reg_valid = lf[4] | lf[5];
                reg_write = lf[6];
                reg_addr  = AW'(lf[9:7] % 4);
                reg_wdata = {lf[0], lf[30:0]};
                @(negedge clk);
            end
            idle(); idle();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule